// File: doc/BRIEF.md
# Network Function Power-State Controller

This block holds the power state of one network interface function on a PCI-style bus and derives from it the enables that gate bus mastering, interrupts and link upkeep. Software selects the wanted device state by writing a two-bit code into a configuration register. The block also watches three other things: the writes that program the function's base address registers, the link status from the physical layer and a pulse from the wake-packet matcher.

After power-on the function sits in an uninitialised D0 substate. It answers slave accesses and keeps wake support active, but it does not master the bus. The first write to a base address register moves it to active D0. In D1, D2 and D3 bus mastering and interrupts are off and wake events are recorded in a sticky status bit. The active-low PME# output is asserted while that status bit and its enable bit are both set.

In D2 and D3, when the link is down and a driver bit allows it, the block enters a deep link power-down. In that mode it stops link keep-alive signalling and responds only to the link becoming valid again.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset the following hold: `cur_state` is 0 (uninitialised D0), bus mastering and interrupts are disabled, link keep-alive is enabled, deep power-down is off, PME status and PME enable are 0, and `pme_n` is 1.
- R2: While `cur_state` is 0, a pulse on any bit of `bar_init_we` moves the state to 1 (active D0) at the next clock edge. In any other state the pulse leaves the state unchanged.
- R3: `bus_master_en` and `irq_en` are 1 only in state 1. In every other state both are 0.
- R4: A state write with code 1, 2 or 3 moves the state to D1, D2 or D3 (`cur_state` 2, 3 or 4) at the next edge, from any state. A write of code 0 while in state 0 or 1 leaves the state unchanged.
- R5: A write of code 0 from D1, D2 or D3 moves the state to 0 if `bar_lost` is 1, and to 1 otherwise.
- R6: A wake event sets PME status at the next edge while the state is 0, 2, 3 or 4. A wake event is a `wake_pkt` pulse or any change of `link_up`.
- R7: PME status stays set until a `pme_sts_w1c` pulse clears it. If a wake event and a clear pulse arrive in the same cycle, the status is set.
- R8: `pme_n` is 0 exactly when PME status and PME enable are both 1. `pme_en_we` loads PME enable from `pme_en_wdata`.
- R9: Deep power-down turns on one edge after the following all hold with no state write in that cycle: the state is D2 or D3, `link_up` is 0 and `dpd_enable` is 1. It never turns on in D1 or while `dpd_enable` is 0. While it is on, `link_keepalive_en` is 0.
- R10: Deep power-down turns off in the same cycle that `link_up` rises, and that rise counts as a wake event. It also turns off together with a state change out of D2 or D3.
- R11: While deep power-down is on, a `wake_pkt` pulse does not set PME status.
- R12: In D3 with PME enable 0, `link_keepalive_en` is 0 and wake events do not set PME status.
- R13: In active D0 (state 1), wake events do not set PME status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| dstate_we | input | 1 | Write strobe for the requested device state |
| dstate_wdata | input | 2 | Requested state code: 0=D0, 1=D1, 2=D2, 3=D3 |
| bar_init_we | input | NUM_BARS | One strobe per base address register write |
| bar_lost | input | 1 | Base address contents lost; selects the return substate |
| pme_en_we | input | 1 | Write strobe for PME enable |
| pme_en_wdata | input | 1 | New PME enable value |
| pme_sts_w1c | input | 1 | Write-one-to-clear pulse for PME status |
| dpd_enable | input | 1 | Driver bit that allows deep link power-down |
| link_up | input | 1 | Link valid indication |
| wake_pkt | input | 1 | Wake packet received pulse |
| cur_state | output | 3 | 0=D0 uninit, 1=D0 active, 2=D1, 3=D2, 4=D3 |
| bus_master_en | output | 1 | Bus mastering allowed |
| irq_en | output | 1 | Interrupts allowed |
| link_keepalive_en | output | 1 | Transmit idle symbols and link pulses |
| link_deep_pd | output | 1 | Deep link power-down active |
| pme_sts | output | 1 | Sticky PME status |
| pme_en | output | 1 | PME enable |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The following results appear one clock edge after their stimulus: state changes, PME status and PME enable updates, and entry into deep power-down. `pme_n`, `bus_master_en` and `irq_en` follow those registers in the same cycle that the registers change. The exit from deep power-down and the keep-alive enable respond combinationally to `link_up`. The bench therefore drives inputs on the falling edge and samples registered results at the next falling edge. It samples the combinational link responses 1 ns after driving `link_up`, before any edge has passed.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

   localparam int REQ_W = 2;

   typedef enum logic [2:0] {
      PS_D0U = 3'd0,
      PS_D0A = 3'd1,
      PS_D1  = 3'd2,
      PS_D2  = 3'd3,
      PS_D3  = 3'd4
   } pwr_state_e;

   localparam logic [REQ_W-1:0] REQ_D0 = 2'd0;
   localparam logic [REQ_W-1:0] REQ_D1 = 2'd1;
   localparam logic [REQ_W-1:0] REQ_D2 = 2'd2;
   localparam logic [REQ_W-1:0] REQ_D3 = 2'd3;

   function automatic logic is_low_power(input pwr_state_e s);
      return (s == PS_D1) || (s == PS_D2) || (s == PS_D3);
   endfunction

   function automatic logic is_deep_capable(input pwr_state_e s);
      return (s == PS_D2) || (s == PS_D3);
   endfunction

endpackage

// File: rtl/pwr_fsm.sv
module pwr_fsm
   import pwr_state_pkg::*;
#(
   parameter int NUM_BARS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dstate_we,
   input  logic [REQ_W-1:0]    dstate_wdata,
   input  logic [NUM_BARS-1:0] bar_init_we,
   input  logic                bar_lost,
   output pwr_state_e          state_o
);

   if (NUM_BARS < 1 || NUM_BARS > 6) begin : g_bad_bars
      $error("pwr_fsm: NUM_BARS must be within 1..6");
   end

   pwr_state_e state_q, state_d;
   logic       any_bar;

   assign any_bar = |bar_init_we;

   always_comb begin
      state_d = state_q;
      if (dstate_we) begin
         unique case (dstate_wdata)
            REQ_D0: if (is_low_power(state_q))
                       state_d = bar_lost ? PS_D0U : PS_D0A;
            REQ_D1: state_d = PS_D1;
            REQ_D2: state_d = PS_D2;
            REQ_D3: state_d = PS_D3;
            default: state_d = state_q;
         endcase
      end else if (state_q == PS_D0U && any_bar) begin
         state_d = PS_D0A;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_D0U;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   // R2
   bar_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_D0U && any_bar && !dstate_we) |=> (state_q == PS_D0A));

   // R4
   req_d1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dstate_we && dstate_wdata == REQ_D1) |=> (state_q == PS_D1));

   // R5
   ret_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dstate_we && dstate_wdata == REQ_D0 && is_low_power(state_q) && !bar_lost)
      |=> (state_q == PS_D0A));

endmodule

// File: rtl/pme_ctl.sv
module pme_ctl
   import pwr_state_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e state_i,
   input  logic       link_up,
   input  logic       wake_pkt,
   input  logic       deep_pd,
   input  logic       pme_en_we,
   input  logic       pme_en_wdata,
   input  logic       pme_sts_w1c,
   output logic       pme_sts,
   output logic       pme_en,
   output logic       pme_n
);

   logic link_q;
   logic sts_q, en_q;
   logic wake_evt, wake_armed, set_sts;

   assign wake_evt   = (link_up ^ link_q) | (wake_pkt & ~deep_pd);
   assign wake_armed = (state_i != PS_D0A) && !(state_i == PS_D3 && !en_q);
   assign set_sts    = wake_evt & wake_armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q <= 1'b0;
         sts_q  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         link_q <= link_up;
         if (set_sts)          sts_q <= 1'b1;
         else if (pme_sts_w1c) sts_q <= 1'b0;
         if (pme_en_we)        en_q  <= pme_en_wdata;
      end
   end

   assign pme_sts = sts_q;
   assign pme_en  = en_q;
   assign pme_n   = ~(sts_q & en_q);

   // R7
   sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !pme_sts_w1c) |=> sts_q);

   // R13
   d0a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == PS_D0A && !sts_q) |=> !sts_q);

endmodule

// File: rtl/link_pd_ctl.sv
module link_pd_ctl
   import pwr_state_pkg::*;
#(
   parameter bit DPD_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e state_i,
   input  logic       link_up,
   input  logic       dpd_enable,
   input  logic       dstate_we,
   output logic       deep_pd
);

   if (DPD_SUPPORT) begin : g_dpd
      logic dpd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dpd_q <= 1'b0;
         else        dpd_q <= is_deep_capable(state_i) && !link_up &&
                              dpd_enable && !dstate_we;
      end

      assign deep_pd = dpd_q & ~link_up & is_deep_capable(state_i);

      // R9
      dpd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(deep_pd) |-> $past(dpd_enable));
   end else begin : g_no_dpd
      logic unused_in;
      assign unused_in = ^{clk, rst_n, state_i, link_up, dpd_enable, dstate_we};
      assign deep_pd   = 1'b0;
   end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
   import pwr_state_pkg::*;
#(
   parameter int NUM_BARS    = 3,
   parameter bit DPD_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dstate_we,
   input  logic [1:0]          dstate_wdata,
   input  logic [NUM_BARS-1:0] bar_init_we,
   input  logic                bar_lost,
   input  logic                pme_en_we,
   input  logic                pme_en_wdata,
   input  logic                pme_sts_w1c,
   input  logic                dpd_enable,
   input  logic                link_up,
   input  logic                wake_pkt,
   output logic [2:0]          cur_state,
   output logic                bus_master_en,
   output logic                irq_en,
   output logic                link_keepalive_en,
   output logic                link_deep_pd,
   output logic                pme_sts,
   output logic                pme_en,
   output logic                pme_n
);

   pwr_state_e state;
   logic       deep_pd;
   logic       pme_en_int;

   pwr_fsm #(.NUM_BARS(NUM_BARS)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .dstate_we    (dstate_we),
      .dstate_wdata (dstate_wdata),
      .bar_init_we  (bar_init_we),
      .bar_lost     (bar_lost),
      .state_o      (state)
   );

   link_pd_ctl #(.DPD_SUPPORT(DPD_SUPPORT)) u_lpd (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_i    (state),
      .link_up    (link_up),
      .dpd_enable (dpd_enable),
      .dstate_we  (dstate_we),
      .deep_pd    (deep_pd)
   );

   pme_ctl u_pme (
      .clk          (clk),
      .rst_n        (rst_n),
      .state_i      (state),
      .link_up      (link_up),
      .wake_pkt     (wake_pkt),
      .deep_pd      (deep_pd),
      .pme_en_we    (pme_en_we),
      .pme_en_wdata (pme_en_wdata),
      .pme_sts_w1c  (pme_sts_w1c),
      .pme_sts      (pme_sts),
      .pme_en       (pme_en_int),
      .pme_n        (pme_n)
   );

   assign cur_state         = state;
   assign bus_master_en     = (state == PS_D0A);
   assign irq_en            = (state == PS_D0A);
   assign link_deep_pd      = deep_pd;
   assign pme_en            = pme_en_int;
   assign link_keepalive_en = ~deep_pd & ~(state == PS_D3 && !pme_en_int);

   // R3
   no_master_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dstate_we && dstate_wdata != 2'd0) |=> (!bus_master_en && !irq_en));

endmodule

// File: tb/tb_pwr_state_ctl.sv
`timescale 1ns/1ps
module tb_pwr_state_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dstate_we = 0;
   logic [1:0] dstate_wdata = 0;
   logic [2:0] bar_init_we = 0;
   logic       bar_lost = 0, pme_en_we = 0, pme_en_wdata = 0, pme_sts_w1c = 0;
   logic       dpd_enable = 0, link_up = 0, wake_pkt = 0;
   logic [2:0] cur_state;
   logic       bus_master_en, irq_en, link_keepalive_en, link_deep_pd;
   logic       pme_sts, pme_en, pme_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pwr_state_ctl dut (
      .clk(clk), .rst_n(rst_n), .dstate_we(dstate_we), .dstate_wdata(dstate_wdata),
      .bar_init_we(bar_init_we), .bar_lost(bar_lost), .pme_en_we(pme_en_we),
      .pme_en_wdata(pme_en_wdata), .pme_sts_w1c(pme_sts_w1c), .dpd_enable(dpd_enable),
      .link_up(link_up), .wake_pkt(wake_pkt), .cur_state(cur_state),
      .bus_master_en(bus_master_en), .irq_en(irq_en),
      .link_keepalive_en(link_keepalive_en), .link_deep_pd(link_deep_pd),
      .pme_sts(pme_sts), .pme_en(pme_en), .pme_n(pme_n)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_state(input logic [1:0] code);
      dstate_we = 1; dstate_wdata = code; step(); dstate_we = 0;
   endtask

   task automatic wr_pme_en(input logic v);
      pme_en_we = 1; pme_en_wdata = v; step(); pme_en_we = 0;
   endtask

   task automatic clr_sts();
      pme_sts_w1c = 1; step(); pme_sts_w1c = 0;
   endtask

   task automatic pulse_wake();
      wake_pkt = 1; step(); wake_pkt = 0;
   endtask

   task automatic t_reset();
      rst_n = 0; repeat (3) step(); rst_n = 1; step();
      check("R1", "state", cur_state, 0);
      check("R1", "bus_master", bus_master_en, 0);
      check("R1", "irq", irq_en, 0);
      check("R1", "keepalive", link_keepalive_en, 1);
      check("R1", "deep_pd", link_deep_pd, 0);
      check("R1", "pme_sts", pme_sts, 0);
      check("R1", "pme_en", pme_en, 0);
      check("R1", "pme_n", pme_n, 1);
   endtask

   task automatic t_bar_init();
      wr_state(2'd0);
      check("R4", "D0 write in uninit", cur_state, 0);
      bar_init_we = 3'b100; step(); bar_init_we = 0;
      check("R2", "bar exits uninit", cur_state, 1);
      check("R3", "bus_master active", bus_master_en, 1);
      check("R3", "irq active", irq_en, 1);
      bar_init_we = 3'b001; step(); bar_init_we = 0;
      check("R2", "bar in active", cur_state, 1);
   endtask

   task automatic t_active_wake();
      wr_pme_en(1);
      check("R8", "pme_en load", pme_en, 1);
      pulse_wake();
      check("R13", "pkt in D0 active", pme_sts, 0);
      link_up = 1; step();
      check("R13", "link change in D0 active", pme_sts, 0);
      check("R13", "pme_n in D0 active", pme_n, 1);
   endtask

   task automatic t_d1_pme();
      wr_state(2'd1);
      check("R4", "enter D1", cur_state, 2);
      check("R3", "bus_master D1", bus_master_en, 0);
      check("R3", "irq D1", irq_en, 0);
      check("R9", "keepalive D1", link_keepalive_en, 1);
      bar_init_we = 3'b010; step(); bar_init_we = 0;
      check("R2", "bar in D1", cur_state, 2);
      pulse_wake();
      check("R6", "pkt sets sts", pme_sts, 1);
      check("R8", "pme_n asserted", pme_n, 0);
      step();
      check("R7", "sts sticky", pme_sts, 1);
      wr_pme_en(0);
      check("R8", "pme_n off when disabled", pme_n, 1);
      check("R7", "sts kept", pme_sts, 1);
      wr_pme_en(1);
      check("R8", "pme_n back", pme_n, 0);
      clr_sts();
      check("R7", "w1c clears", pme_sts, 0);
      check("R8", "pme_n after clear", pme_n, 1);
      pme_sts_w1c = 1; wake_pkt = 1; step(); pme_sts_w1c = 0; wake_pkt = 0;
      check("R7", "set beats clear", pme_sts, 1);
      clr_sts();
   endtask

   task automatic t_return_d0();
      bar_lost = 0; wr_state(2'd0);
      check("R5", "D0 kept bars", cur_state, 1);
      wr_state(2'd2);
      check("R4", "enter D2", cur_state, 3);
      bar_lost = 1; wr_state(2'd0); bar_lost = 0;
      check("R5", "D0 lost bars", cur_state, 0);
      pulse_wake();
      check("R6", "pkt in uninit sets", pme_sts, 1);
      clr_sts();
      bar_init_we = 3'b001; step(); bar_init_we = 0;
      check("R2", "bar after return", cur_state, 1);
   endtask

   task automatic t_deep_pd();
      dpd_enable = 1;
      wr_state(2'd2);
      check("R9", "no dpd with link", link_deep_pd, 0);
      link_up = 0; step();
      check("R9", "dpd entered", link_deep_pd, 1);
      check("R9", "keepalive off", link_keepalive_en, 0);
      check("R6", "link drop sets", pme_sts, 1);
      clr_sts();
      pulse_wake();
      check("R11", "pkt ignored in dpd", pme_sts, 0);
      link_up = 1; #1;
      check("R10", "dpd exit on link", link_deep_pd, 0);
      check("R10", "keepalive on link", link_keepalive_en, 1);
      step();
      check("R10", "link rise wakes", pme_sts, 1);
      clr_sts();
      wr_state(2'd1);
      link_up = 0; step(); step();
      check("R9", "no dpd in D1", link_deep_pd, 0);
      dpd_enable = 0; wr_state(2'd3); step();
      check("R9", "no dpd when disabled", link_deep_pd, 0);
      dpd_enable = 1; step();
      check("R9", "dpd in D3", link_deep_pd, 1);
      bar_lost = 0; wr_state(2'd0);
      check("R10", "state after exit", cur_state, 1);
      check("R10", "dpd off on state change", link_deep_pd, 0);
      clr_sts();
      dpd_enable = 0;
   endtask

   task automatic t_d3_nopme();
      link_up = 1; step();
      wr_pme_en(0);
      wr_state(2'd3);
      check("R12", "keepalive off D3", link_keepalive_en, 0);
      pulse_wake();
      check("R12", "pkt ignored D3", pme_sts, 0);
      link_up = 0; step();
      check("R12", "link ignored D3", pme_sts, 0);
      link_up = 1; step();
      wr_pme_en(1);
      check("R12", "keepalive with pme", link_keepalive_en, 1);
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_bar_init();
      t_active_wake();
      t_d1_pme();
      t_return_d0();
      t_deep_pd();
      t_d3_nopme();
      report();
   end

   initial begin
      #100000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule